// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one block-transfer request into a stream of single-word transfers. A request carries a base address, a 16-bit bitmap that selects the registers taking part, one of four addressing modes and a writeback enable. After accepting the request, the sequencer presents one word address and one register index per transfer under a valid/ready handshake. Once the last transfer is taken it raises a one-cycle completion pulse together with the updated base value.

Every mode places the selected registers in a contiguous block of words, with the lowest-numbered register at the lowest address. The mode only sets where that block sits relative to the base, and which way the base moves on writeback. A descending-before store with writeback, followed by an ascending-after load with writeback from the returned base, therefore behaves as a stack push and its matching pop. The memory port, the register file and the instruction decode sit outside this block.

Top module: `lsm_addr_seq`

## Requirements
- R1: With N set bits in the list and A the base with its low two bits cleared, the first address is A for mode 0 (ascend-after), A+4 for mode 1 (ascend-before), A-4N+4 for mode 2 (descend-after) and A-4N for mode 3 (descend-before).
- R2: Registers are presented in ascending index order, skipping clear bits, and each address after the first is 4 above the previous one.
- R3: Every presented address has bits [1:0] equal to zero.
- R4: While `xfer_valid_o` is high and `xfer_ready_i` is low, the address and register index are held unchanged in the next cycle.
- R5: Exactly N transfers are presented. `done_o` is high for exactly one cycle, in the cycle right after the last accepted transfer.
- R6: While `done_o` is high, `wb_base_o` equals the unmodified base plus 4N for modes 0 and 1, or minus 4N for modes 2 and 3. `wb_we_o` is high only in that cycle, and only if the writeback enable was set at request time.
- R7: An empty list presents no transfer. `done_o` rises in the cycle after acceptance, and `wb_base_o` equals the base unchanged.
- R8: `start_ready_o` is high only when idle. Request inputs driven while a request is in progress have no effect on the running sequence.
- R9: Asynchronous reset returns the block to idle: `start_ready_o` high, `xfer_valid_o` and `done_o` low, even in the middle of a sequence.
- R10: A mode-3 request with writeback, followed by a mode-0 request on the same list from the returned base, covers the same addresses and restores the original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_valid_i | input | 1 | Request present |
| start_ready_o | output | 1 | Idle and able to accept a request |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Register selection bitmap, bit i selects register i |
| mode_i | input | 2 | Addressing mode: 0 ascend-after, 1 ascend-before, 2 descend-after, 3 descend-before |
| wb_en_i | input | 1 | Request base writeback |
| xfer_valid_o | output | 1 | Transfer presented |
| xfer_ready_i | input | 1 | Downstream takes the presented transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| done_o | output | 1 | One-cycle completion pulse |
| wb_we_o | output | 1 | Base writeback strobe |
| wb_base_o | output | 32 | Updated base value |

## Verification
The internal state is a remaining-register mask, an address accumulator and a phase. Each of them is visible at the ports within one cycle of going wrong. A corrupted mask shows up on the next transfer as a wrong or repeated register index, or as a transfer count that differs from N, so `done_o` arrives early or late. A slip in the accumulator shows up as a wrong address on the first transfer after the handshake in which it occurred. Holding `xfer_ready_i` low at irregular points, and driving fresh request inputs while busy, show whether any of this state moves when it should not.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_IA = 2'd0,
    MODE_IB = 2'd1,
    MODE_DA = 2'd2,
    MODE_DB = 2'd3
  } lsm_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_acc
    assign part[i+1] = part[i] + CW'(vec_i[i]);
  end
  assign cnt_o = part[W];
endmodule

// File: rtl/lsm_lowest_set.sv
module lsm_lowest_set #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
  import lsm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 5,
  parameter int WORD_B = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  lsm_mode_e     mode_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  localparam int SH = $clog2(WORD_B);

  logic [AW-1:0] aligned, span, step;

  assign aligned = base_i & ~AW'(WORD_B - 1);
  assign span    = AW'(cnt_i) << SH;
  assign step    = AW'(WORD_B);

  always_comb begin
    unique case (mode_i)
      MODE_IA: first_o = aligned;
      MODE_IB: first_o = aligned + step;
      MODE_DA: first_o = aligned - span + step;
      default: first_o = aligned - span;
    endcase
  end

  // writeback moves the raw base, low bits kept
  assign wb_o = mode_i[1] ? base_i - span : base_i + span;
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NREG   = 16,
  parameter int WORD_B = 4,
  parameter int RW     = $clog2(NREG),
  parameter int CW     = $clog2(NREG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_valid_i,
  output logic          start_ready_o,
  input  logic [AW-1:0] base_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [1:0]    mode_i,
  input  logic          wb_en_i,
  output logic          xfer_valid_o,
  input  logic          xfer_ready_i,
  output logic [AW-1:0] xfer_addr_o,
  output logic [RW-1:0] xfer_reg_o,
  output logic          done_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_base_o
);
  lsm_state_e      state_q;
  logic [NREG-1:0] rem_q, rem_next;
  logic [AW-1:0]   addr_q, wb_base_q;
  logic            wb_en_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr, wb_calc;
  logic [RW-1:0]   cur_idx;
  logic            accept, fire;

  lsm_popcnt #(.W(NREG), .CW(CW)) u_popcnt (
    .vec_i (reg_list_i),
    .cnt_o (cnt)
  );

  lsm_addr_calc #(.AW(AW), .CW(CW), .WORD_B(WORD_B)) u_calc (
    .base_i  (base_i),
    .cnt_i   (cnt),
    .mode_i  (lsm_mode_e'(mode_i)),
    .first_o (first_addr),
    .wb_o    (wb_calc)
  );

  lsm_lowest_set #(.W(NREG), .IW(RW)) u_lowest (
    .vec_i (rem_q),
    .idx_o (cur_idx)
  );

  assign accept   = start_valid_i && (state_q == ST_IDLE);
  assign fire     = (state_q == ST_XFER) && xfer_ready_i;
  assign rem_next = rem_q & ~(NREG'(1) << cur_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      addr_q    <= '0;
      wb_base_q <= '0;
      wb_en_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          rem_q     <= reg_list_i;
          addr_q    <= first_addr;
          wb_base_q <= wb_calc;
          wb_en_q   <= wb_en_i;
          state_q   <= (reg_list_i == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (fire) begin
          rem_q  <= rem_next;
          addr_q <= addr_q + AW'(WORD_B);
          if (rem_next == '0) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready_o = (state_q == ST_IDLE);
  assign xfer_valid_o  = (state_q == ST_XFER);
  assign xfer_addr_o   = addr_q;
  assign xfer_reg_o    = cur_idx;
  assign done_o        = (state_q == ST_DONE);
  assign wb_we_o       = done_o && wb_en_q;
  assign wb_base_o     = wb_base_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_ready_o,
  input logic          xfer_valid_o,
  input logic          xfer_ready_i,
  input logic [AW-1:0] xfer_addr_o,
  input logic [RW-1:0] xfer_reg_o,
  input logic          done_o,
  input logic          wb_we_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)); // R4

  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> xfer_addr_o[1:0] == 2'b00); // R3

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_ready_i |=> !xfer_valid_o || (xfer_addr_o == $past(xfer_addr_o) + AW'(4))); // R2

  AST_REG_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_ready_i |=> !xfer_valid_o || (xfer_reg_o > $past(xfer_reg_o))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && start_ready_o); // R5

  AST_WB_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> done_o); // R6

  AST_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ready_o |-> !xfer_valid_o && !done_o); // R8
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_ready_o (start_ready_o),
  .xfer_valid_o  (xfer_valid_o),
  .xfer_ready_i  (xfer_ready_i),
  .xfer_addr_o   (xfer_addr_o),
  .xfer_reg_o    (xfer_reg_o),
  .done_o        (done_o),
  .wb_we_o       (wb_we_o)
);

// File: tb/lsm_addr_seq_tb_top.sv
module lsm_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] list;
    logic [1:0]  mode;
    logic        wb;
    logic        stall;
    logic        junk;
    logic [31:0] first;
    logic [31:0] wbv;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 16'h40E0, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_0FF0, 32'h0000_0FF0},
    '{32'h0000_0FF0, 16'h80E0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_0FF0, 32'h0000_1000},
    '{32'h0000_2000, 16'h0003, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0000_2004, 32'h0000_2008},
    '{32'h0000_2000, 16'h8001, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_1FFC, 32'h0000_1FF8},
    '{32'h0000_3000, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_2FC4, 32'h0000_2FC0},
    '{32'h0000_4003, 16'h0010, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_4004, 32'h0000_4007},
    '{32'h0000_0004, 16'h0006, 2'd3, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFC},
    '{32'h0000_5000, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_5000, 32'h0000_5000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] base_in = '0;
  logic [15:0] list_in = '0;
  logic [1:0]  mode_in = '0;
  logic        wb_en = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [3:0]  xfer_reg;
  logic        done;
  logic        wb_we;
  logic [31:0] wb_base;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_addr_seq dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .start_valid_i (start_valid),
    .start_ready_o (start_ready),
    .base_i        (base_in),
    .reg_list_i    (list_in),
    .mode_i        (mode_in),
    .wb_en_i       (wb_en),
    .xfer_valid_o  (xfer_valid),
    .xfer_ready_i  (xfer_ready),
    .xfer_addr_o   (xfer_addr),
    .xfer_reg_o    (xfer_reg),
    .done_o        (done),
    .wb_we_o       (wb_we),
    .wb_base_o     (wb_base)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic run_op(input vec_t v, output logic [31:0] got_wb, output logic [31:0] got_first);
    logic [15:0] rem;
    int n, k, cyc, lowest;
    bit stalled;
    rem = v.list;
    n = $countones(v.list);
    k = 0; cyc = 0; stalled = 0;
    got_first = '0;
    @(negedge clk);
    chk(start_ready === 1'b1, "R8", "ready when idle", 32'(start_ready), 32'd1);
    start_valid = 1'b1;
    base_in = v.base; list_in = v.list; mode_in = v.mode; wb_en = v.wb;
    @(posedge clk);
    @(negedge clk);
    if (v.junk) begin
      base_in = 32'hDEAD_0000; list_in = 16'h5555; mode_in = ~v.mode; wb_en = ~v.wb;
    end else begin
      start_valid = 1'b0;
    end
    for (int it = 0; it < 100; it++) begin
      if (k == n) begin
        chk(done === 1'b1 && xfer_valid === 1'b0, (n == 0) ? "R7" : "R5",
            "done after last transfer", 32'(done), 32'd1);
        chk(wb_base === v.wbv, (n == 0) ? "R7" : "R6", "wb_base", wb_base, v.wbv);
        chk(wb_we === v.wb, "R6", "wb_we", 32'(wb_we), 32'(v.wb));
        got_wb = wb_base;
        start_valid = 1'b0;
        break;
      end
      lowest = 0;
      for (int b = 15; b >= 0; b--) if (rem[b]) lowest = b;
      chk(xfer_valid === 1'b1 && start_ready === 1'b0 && done === 1'b0, "R8",
          "busy while transferring", 32'(xfer_valid), 32'd1);
      chk(xfer_addr === v.first + 32'(4 * k), (k == 0) ? "R1" : (stalled ? "R4" : "R2"),
          "address", xfer_addr, v.first + 32'(4 * k));
      chk(xfer_reg === 4'(lowest), stalled ? "R4" : "R2", "register", 32'(xfer_reg), 32'(lowest));
      chk(xfer_addr[1:0] === 2'b00, "R3", "alignment", 32'(xfer_addr[1:0]), 32'd0);
      if (k == 0) got_first = xfer_addr;
      xfer_ready = v.stall ? ((cyc % 3) != 1) : 1'b1;
      stalled = !xfer_ready;
      cyc++;
      @(posedge clk);
      @(negedge clk);
      if (xfer_ready) begin
        k++;
        rem[lowest] = 1'b0;
      end
      xfer_ready = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && start_ready === 1'b1, "R5", "done one cycle only", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] wbv, f_push, f_pop, wb_push, wb_pop;
    vec_t v;
    #(CLK_PERIOD * 2);
    chk(start_ready === 1'b1 && xfer_valid === 1'b0 && done === 1'b0, "R9",
        "in reset", {29'd0, start_ready, xfer_valid, done}, 32'h4);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(start_ready === 1'b1 && xfer_valid === 1'b0 && done === 1'b0, "R9",
        "after reset", {29'd0, start_ready, xfer_valid, done}, 32'h4);

    for (int i = 0; i < NVEC; i++) run_op(VECS[i], wbv, f_push);

    // R10 push then pop from returned base
    v = '{32'h0000_8000, 16'h40F0, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_7FEC, 32'h0000_7FEC};
    run_op(v, wb_push, f_push);
    v = '{wb_push, 16'h40F0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_7FEC, 32'h0000_8000};
    run_op(v, wb_pop, f_pop);
    chk(f_pop === f_push, "R10", "pop covers pushed words", f_pop, f_push);
    chk(wb_pop === 32'h0000_8000, "R10", "base restored", wb_pop, 32'h0000_8000);

    // R9 reset mid-sequence
    @(negedge clk);
    start_valid = 1'b1; base_in = 32'h100; list_in = 16'h00FF; mode_in = 2'd0; wb_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    chk(xfer_valid === 1'b1, "R9", "busy before reset", 32'(xfer_valid), 32'd1);
    rst_ni = 1'b0;
    #1;
    chk(start_ready === 1'b1 && xfer_valid === 1'b0 && done === 1'b0, "R9",
        "async reset mid-sequence", {29'd0, start_ready, xfer_valid, done}, 32'h4);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(xfer_valid === 1'b0 && done === 1'b0, "R9", "idle after reset release",
        32'(xfer_valid), 32'd0);

    summary();
  end
endmodule